// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the single active-low parity line of a multiplexed 16-bit address/data bus. When the local device drives the bus (as master during an address phase or as talker during a data phase), the parity output follows the outgoing AD value. The line is low when an odd number of the covered AD bits are high, and high when that number is even. When the device only listens, it samples the incoming AD value and parity line once per transfer, at the falling edge of the data-ready strobe. A mismatch sets a sticky error.

A 2-bit mode input picks which bits parity covers. The block also honours a no-parity mode and two 8-bit device variants. A sticky error pulls the shared, active-low take-over interrupt line low, unless the block belongs to the bus supervisor, which already knows of the error. The error and the interrupt stay set until an external clear.

Top module: `bus_parity_unit`

## Requirements
- R1: After synchronous reset, `err_o` is 0 and `sto_n_o` is 1.
- R2: In mode 1 (full), while `talk_i` is 1, `pb_n_o` is 0 when an odd number of the 16 bits of `ad_tx_i` are 1, and 1 when that number is even, in both phases.
- R3: In mode 2 (8-bit-only system), parity covers only `ad_tx_i[7:0]` for generation and `ad_rx_i[7:0]` for checking, in both phases.
- R4: In mode 3 (8-bit device on a mixed bus), parity covers all 16 bits when `phase_i` is 0 (address) and only bits 7:0 when `phase_i` is 1 (data), for both generation and checking.
- R5: In mode 0 (no parity), `pb_n_o` stays 1, and no transfer can set `err_o`.
- R6: While `talk_i` is 0, `pb_n_o` is 1. While `talk_i` is 1, received transfers are not checked.
- R7: `drdy_n_i` passes through a 2-flop synchronizer. The bus is sampled once, on the synchronized falling edge. On a mismatch, `err_o` rises at the third rising clock edge after `drdy_n_i` goes low, and not earlier.
- R8: Only one sample is taken per strobe. A bus change while `drdy_n_i` stays low cannot set the error.
- R9: `err_o` is sticky until `err_clr_i`. If a mismatch is detected in the same cycle as a clear, the error wins.
- R10: `sto_n_o` is low exactly when `err_o` is 1 and `supv_i` is 0. A supervisor-owned block sets `err_o` but keeps `sto_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Parity mode: 0 none, 1 full, 2 8-bit system, 3 mixed bus 8-bit device |
| phase_i | input | 1 | 0 address phase, 1 data phase |
| talk_i | input | 1 | 1 when this device drives AD (master/talker) |
| supv_i | input | 1 | 1 when the block belongs to the supervisor |
| ad_tx_i | input | 16 | Outgoing AD value |
| pb_n_o | output | 1 | Generated active-low parity |
| ad_rx_i | input | 16 | AD value seen on the bus |
| pb_n_i | input | 1 | Parity line seen on the bus |
| drdy_n_i | input | 1 | Asynchronous active-low data-ready strobe |
| err_clr_i | input | 1 | Clears the sticky error |
| err_o | output | 1 | Sticky parity error |
| sto_n_o | output | 1 | Active-low take-over interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same clock as the one-cycle sample strobe. That strobe exists only inside the block, two edges after the asynchronous strobe falls. The bench counts edges from the moment it lowers `drdy_n_i` and raises `err_clr_i` exactly over the third edge. The single-sample rule is reached a similar way: a correct word is held, and then the AD lines are corrupted while the strobe is still low.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    localparam int AD_W   = 16;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        PM_OFF    = 2'd0,
        PM_FULL   = 2'd1,
        PM_NARROW = 2'd2,
        PM_MIXED  = 2'd3
    } pmode_e;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        pmode_e mode;
        phase_e phase;
    } pctx_t;

    // True when the context restricts parity to the low byte lane.
    function automatic logic lane_only(pctx_t c);
        return (c.mode == PM_NARROW) || (c.mode == PM_MIXED && c.phase == PH_DATA);
    endfunction

    // Active-low parity level for a word: 0 on odd ones-count.
    function automatic logic pb_level(pctx_t c, logic [AD_W-1:0] w);
        logic ones;
        if (lane_only(c)) ones = ^w[LANE_W-1:0];
        else              ones = ^w;
        return ~ones;
    endfunction
endpackage

// File: rtl/bpc_pgen.sv
module bpc_pgen
    import bpc_pkg::*;
(
    input  pctx_t           ctx_i,
    input  logic            talk_i,
    input  logic [AD_W-1:0] ad_i,
    output logic            pb_n_o
);
    always_comb begin
        if (talk_i && ctx_i.mode != PM_OFF) pb_n_o = pb_level(ctx_i, ad_i);
        else                                pb_n_o = 1'b1;
    end
endmodule

// File: rtl/bpc_edge.sv
module bpc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n_i,
    output logic fall_o
);
    localparam int CHAIN = SYNC_STAGES + 1;
    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= strobe_n_i;
    end

    for (genvar g = 1; g < CHAIN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b1;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign fall_o = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/bpc_chk.sv
module bpc_chk
    import bpc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pctx_t           ctx_i,
    input  logic            talk_i,
    input  logic            fall_i,
    input  logic [AD_W-1:0] ad_i,
    input  logic            pb_n_i,
    input  logic            clr_i,
    output logic            err_o
);
    logic armed, bad, hit;

    assign armed = (ctx_i.mode != PM_OFF) && !talk_i;
    assign bad   = pb_n_i != pb_level(ctx_i, ad_i);
    assign hit   = fall_i && armed && bad;

    always_ff @(posedge clk) begin
        if (rst)        err_o <= 1'b0;
        else if (hit)   err_o <= 1'b1;
        else if (clr_i) err_o <= 1'b0;
    end

    assert_rise_needs_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(fall_i));
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !fall_i) |=> !err_o);
    assert_off_mode_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (ctx_i.mode == PM_OFF && !clr_i && !err_o) |=> !err_o);
    assert_talker_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (talk_i && !clr_i && !err_o) |=> !err_o);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_i,
    input  logic            phase_i,
    input  logic            talk_i,
    input  logic            supv_i,
    input  logic [AD_W-1:0] ad_tx_i,
    output logic            pb_n_o,
    input  logic [AD_W-1:0] ad_rx_i,
    input  logic            pb_n_i,
    input  logic            drdy_n_i,
    input  logic            err_clr_i,
    output logic            err_o,
    output logic            sto_n_o
);
    pctx_t ctx;
    logic  fall;

    assign ctx.mode  = pmode_e'(mode_i);
    assign ctx.phase = phase_e'(phase_i);

    bpc_pgen u_gen (
        .ctx_i  (ctx),
        .talk_i (talk_i),
        .ad_i   (ad_tx_i),
        .pb_n_o (pb_n_o)
    );

    bpc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .strobe_n_i (drdy_n_i),
        .fall_o     (fall)
    );

    bpc_chk u_chk (
        .clk    (clk),
        .rst    (rst),
        .ctx_i  (ctx),
        .talk_i (talk_i),
        .fall_i (fall),
        .ad_i   (ad_rx_i),
        .pb_n_i (pb_n_i),
        .clr_i  (err_clr_i),
        .err_o  (err_o)
    );

    assign sto_n_o = ~(err_o & ~supv_i);

    assert_supv_silent_R10: assert property (@(posedge clk) disable iff (rst)
        supv_i |-> sto_n_o);
    assert_listen_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !talk_i |-> pb_n_o);
endmodule

// File: tb/sim_bus_parity_unit.sv
module sim_bus_parity_unit;
    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  mode = 0;
    logic        phase = 0, talk = 0, supv = 0;
    logic [15:0] ad_tx = 0, ad_rx = 0;
    logic        pb_n_o, pb_in = 1, drdy_n = 1, clr = 0;
    logic        err, sto_n;
    int checks = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bus_parity_unit u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .phase_i(phase), .talk_i(talk),
        .supv_i(supv), .ad_tx_i(ad_tx), .pb_n_o(pb_n_o), .ad_rx_i(ad_rx),
        .pb_n_i(pb_in), .drdy_n_i(drdy_n), .err_clr_i(clr), .err_o(err),
        .sto_n_o(sto_n)
    );

    function automatic logic ref_pb(logic [1:0] m, logic ph, logic [15:0] w);
        logic narrow = (m == 2) || (m == 3 && ph);
        return narrow ? ~(^w[7:0]) : ~(^w);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic xfer(logic [15:0] w, logic p);
        ad_rx = w; pb_in = p; drdy_n = 0;
        repeat (4) @(negedge clk);
        drdy_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1; @(negedge clk); clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 err", err, 1'b0);
        check("R1 sto", sto_n, 1'b1);
        rst = 0;
        @(negedge clk);

        // R2/R3/R4/R5 generation, directed corners
        talk = 1; mode = 1; phase = 0; ad_tx = 16'h0001; #1;
        check("R2 odd", pb_n_o, 1'b0);
        ad_tx = 16'h0101; #1; check("R2 even", pb_n_o, 1'b1);
        mode = 2; ad_tx = 16'h0100; #1; check("R3 high byte ignored", pb_n_o, 1'b1);
        mode = 3; phase = 0; #1; check("R4 addr 16-bit", pb_n_o, 1'b0);
        phase = 1; #1; check("R4 data 8-bit", pb_n_o, 1'b1);
        mode = 0; ad_tx = 16'h0001; #1; check("R5 off gen", pb_n_o, 1'b1);
        talk = 0; mode = 1; #1; check("R6 listener idle", pb_n_o, 1'b1);

        // random generation
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            talk = 1; mode = $urandom % 4; phase = $urandom % 2; ad_tx = $urandom;
            #1;
            check("R2 R3 R4 R5 gen", pb_n_o, (mode == 0) ? 1'b1 : ref_pb(mode, phase, ad_tx));
        end
        talk = 0;
        @(negedge clk);

        // R7 latency
        mode = 1; phase = 0; ad_rx = 16'h0003; pb_in = 0; drdy_n = 0;
        @(negedge clk); @(negedge clk);
        check("R7 not yet", err, 1'b0);
        @(negedge clk);
        check("R7 set on third edge", err, 1'b1);
        check("R10 sto low", sto_n, 1'b0);
        @(negedge clk); drdy_n = 1; repeat (3) @(negedge clk);
        check("R9 sticky", err, 1'b1);
        do_clear();
        check("R9 cleared", err, 1'b0);

        // R10 supervisor
        supv = 1;
        xfer(16'h0001, 1'b1);
        check("R10 supv err", err, 1'b1);
        check("R10 supv sto high", sto_n, 1'b1);
        do_clear(); supv = 0;

        // R6 talker not checked
        talk = 1; xfer(16'h0001, 1'b1);
        check("R6 talker unchecked", err, 1'b0);
        talk = 0;

        // R5 off mode
        mode = 0; xfer(16'h0001, 1'b1);
        check("R5 no check", err, 1'b0);

        // R8 single sample: correct then corrupt while low
        mode = 1; phase = 1; ad_rx = 16'h00F0; pb_in = 1; drdy_n = 0;
        repeat (4) @(negedge clk);
        ad_rx = 16'h00F1;
        repeat (3) @(negedge clk);
        drdy_n = 1; repeat (3) @(negedge clk);
        check("R8 one sample", err, 1'b0);

        // R9 set beats clear
        mode = 1; ad_rx = 16'h0001; pb_in = 1; drdy_n = 0;
        @(negedge clk); @(negedge clk);
        clr = 1; @(negedge clk); clr = 0;
        check("R9 set wins", err, 1'b1);
        drdy_n = 1; repeat (3) @(negedge clk);
        do_clear();

        // random check traffic
        for (int i = 0; i < 80; i++) begin
            logic [15:0] w;
            logic        ph, corrupt, p, exp_err;
            logic [1:0]  m;
            w = $urandom; ph = $urandom % 2; m = $urandom % 4; corrupt = $urandom % 2;
            mode = m; phase = ph;
            p = ref_pb(m, ph, w) ^ corrupt;
            exp_err = (m != 0) && corrupt;
            xfer(w, p);
            check("R3 R4 R7 check", err, exp_err);
            check("R10 sto", sto_n, ~exp_err);
            do_clear();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule